// File: doc/BRIEF.md
# Transport Packet Capture Buffer

This block takes a stream of accepted 188-byte transport packets and stores them, as 32-bit words, into a fixed window of memory that holds eight packets (1504 bytes). The window starts at a programmable base address. Each packet is 47 words long. Every accepted word goes out through a plain one-cycle memory write port, at the next word address in the window.

A single control/status register serves the host. It reports how many packets are in the window. It holds the packet threshold that raises a buffer-done event, a mask for each interrupt source, and a write-one acknowledge that clears every pending flag. It also holds an active-low soft-reset bit for the capture logic. When software has drained the window, it writes the base address again. That write rearms the window: the packet count and the write offset both return to zero.

A packet that starts while all eight slots are full, before any rearm, is consumed from the stream and thrown away, and the overflow flag is raised. The input is valid/ready. `in_ready` is high whenever capture runs, except in a cycle that writes the base address. It is low throughout soft reset, so the source is held back and loses nothing. The block never back-pressures for a full window: that case is overflow, not stall.

Top module: `pkt_capture`

## Requirements
- R1: After hardware reset the register reads count 0, all flags 0, soft-reset bit (15) 0, the four masks (17, 14, 13, 12) set, and threshold (6:0) 4. `irq` is 0 and `in_ready` is 0.
- R2: Each accepted word is written once, one cycle after its beat, to base + 4·k, where k counts the words accepted since the last rearm. Words are written in arrival order.
- R3: The packet count in bits 31:24 rises by one after the 47th word of each stored packet.
- R4: The done flag (bit 16) is set when the count becomes equal to the threshold in bits 6:0. Passing beyond the threshold does not set it again.
- R5: A packet whose first word arrives while the count is 8 is not written. The overflow flag (bit 11) is set and the count stays 8.
- R6: `irq` is high exactly when some flag is set whose mask is clear. The pairs are done 16/mask 17, overflow 11/mask 14, almost-full 10/mask 13, and lock 9/mask 12.
- R7: A register write with bit 8 set clears all four flags. A write with bit 8 clear leaves them alone. A flag event in the same cycle wins over the clear.
- R8: While bit 15 is 0, `in_ready` is 0, no memory write is issued, and the count, offset and flags are held at zero. Setting bit 15 again restarts capture at the base address.
- R9: Writing the base address sets the count and the offset to zero. This rearms a full window, so the next packet is stored at the new base.
- R10: The almost-full flag (bit 10) is set when the count becomes 7. The lock flag (bit 9) is set by a pulse on `lock_evt` while capture runs.
- R11: A beat counts only when `in_valid` and `in_ready` are both high. Idle cycles between beats do not change the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high with valid |
| in_data | input | 32 | Stream word |
| lock_evt | input | 1 | Single-cycle lock event pulse |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 32 | Control/status write data |
| csr_rdata | output | 32 | Control/status read value |
| base_we | input | 1 | Base address write strobe (rearms the window) |
| base_wdata | input | 32 | New base address |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| irq | output | 1 | Interrupt request |

## Verification
A wrong offset or word index shows up at the memory port on the very next write, as an address or a payload out of sequence. A wrong packet count shows up in bits 31:24 one cycle after a 47th word. It then spreads into a done, almost-full or overflow flag that fires on the wrong packet, along with a drop or an extra write at the ninth packet. Flag or mask faults show on `irq` one cycle after the event or the acknowledge. Errors in soft reset or rearm show at the first write after release, which lands somewhere other than the base.

// File: rtl/pkt_capture_pkg.sv
package pkt_capture_pkg;
  localparam int CSR_CNT_LSB   = 24;
  localparam int CSR_CNT_W     = 8;
  localparam int CSR_DONE_MSK  = 17;
  localparam int CSR_DONE_FLG  = 16;
  localparam int CSR_RUN       = 15;
  localparam int CSR_OVR_MSK   = 14;
  localparam int CSR_AFUL_MSK  = 13;
  localparam int CSR_LOCK_MSK  = 12;
  localparam int CSR_OVR_FLG   = 11;
  localparam int CSR_AFUL_FLG  = 10;
  localparam int CSR_LOCK_FLG  = 9;
  localparam int CSR_ACK       = 8;
  localparam int CSR_THR_W     = 7;

  typedef logic [CSR_CNT_W-1:0] pkt_cnt_t;
  typedef logic [CSR_THR_W-1:0] pkt_thr_t;

  typedef struct packed {
    logic done;
    logic ovr;
    logic aful;
    logic lock;
  } cap_flags_t;
endpackage

// File: rtl/cap_wrgen.sv
module cap_wrgen
  import pkt_capture_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PKT_WORDS = 47,
  parameter int BUF_PKTS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output pkt_cnt_t          cnt,
  output logic              ev_pkt,
  output pkt_cnt_t          new_cnt,
  output logic              ev_ovr
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BUF_BYTES  = PKT_WORDS * BUF_PKTS * WORD_BYTES;
  localparam int OFF_W      = $clog2(BUF_BYTES + 1);
  localparam int IDX_W      = $clog2(PKT_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);
  localparam pkt_cnt_t FULL_CNT = pkt_cnt_t'(BUF_PKTS);

  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  widx_q;
  pkt_cnt_t          cnt_q;
  logic              drop_q;

  logic fire, first_w, last_w, start_drop, dropping, wr_now;

  assign in_ready   = run && !base_we;
  assign fire       = in_valid && in_ready;
  assign first_w    = (widx_q == '0);
  assign last_w     = (widx_q == LAST_IDX);
  assign start_drop = fire && first_w && (cnt_q == FULL_CNT);
  assign dropping   = start_drop || drop_q;
  assign wr_now     = fire && !dropping;
  assign ev_pkt     = fire && last_w && !dropping;
  assign new_cnt    = cnt_q + pkt_cnt_t'(1);
  assign ev_ovr     = start_drop;
  assign cnt        = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q    <= '0;
      widx_q   <= '0;
      cnt_q    <= '0;
      drop_q   <= 1'b0;
      mem_wr   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else if (!run || base_we) begin
      off_q  <= '0;
      widx_q <= '0;
      cnt_q  <= '0;
      drop_q <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      mem_wr <= wr_now;
      if (wr_now) begin
        mem_addr <= base_q + ADDR_W'(off_q);
        mem_data <= in_data;
        off_q    <= off_q + OFF_W'(WORD_BYTES);
      end
      if (fire) begin
        widx_q <= last_w ? '0 : widx_q + IDX_W'(1);
        if (last_w) drop_q <= 1'b0;
        else if (start_drop) drop_q <= 1'b1;
      end
      if (ev_pkt) cnt_q <= new_cnt;
    end
  end

  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mem_wr);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  p_drop_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> !mem_wr);
  p_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ((mem_addr - base_q) < ADDR_W'(BUF_BYTES)));
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt |=> (cnt_q == $past(cnt_q) + pkt_cnt_t'(1)));
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (cnt_q == '0 && !mem_wr));
endmodule

// File: rtl/cap_csr.sv
module cap_csr
  import pkt_capture_pkg::*;
#(
  parameter int BUF_PKTS = 8,
  parameter int DEF_THR  = BUF_PKTS / 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  pkt_cnt_t    cnt,
  input  logic        ev_pkt,
  input  pkt_cnt_t    new_cnt,
  input  logic        ev_ovr,
  input  logic        lock_evt,
  output logic        run,
  output logic        irq
);
  localparam pkt_cnt_t AFUL_CNT = pkt_cnt_t'(BUF_PKTS - 1);

  cap_flags_t flg_q, msk_q, set_v;
  pkt_thr_t   thr_q;
  logic       run_q;

  assign set_v.done = ev_pkt && (new_cnt == pkt_cnt_t'(thr_q));
  assign set_v.ovr  = ev_ovr;
  assign set_v.aful = ev_pkt && (new_cnt == AFUL_CNT);
  assign set_v.lock = lock_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      msk_q <= '1;
      thr_q <= pkt_thr_t'(DEF_THR);
    end else if (csr_we) begin
      run_q      <= csr_wdata[CSR_RUN];
      msk_q.done <= csr_wdata[CSR_DONE_MSK];
      msk_q.ovr  <= csr_wdata[CSR_OVR_MSK];
      msk_q.aful <= csr_wdata[CSR_AFUL_MSK];
      msk_q.lock <= csr_wdata[CSR_LOCK_MSK];
      thr_q      <= csr_wdata[CSR_THR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else if (!run_q) flg_q <= '0;
    else if (csr_we && csr_wdata[CSR_ACK]) flg_q <= set_v;
    else flg_q <= flg_q | set_v;
  end

  assign run = run_q;
  assign irq = |(flg_q & ~msk_q);

  always_comb begin
    csr_rdata = '0;
    csr_rdata[CSR_CNT_LSB +: CSR_CNT_W] = cnt;
    csr_rdata[CSR_DONE_MSK] = msk_q.done;
    csr_rdata[CSR_DONE_FLG] = flg_q.done;
    csr_rdata[CSR_RUN]      = run_q;
    csr_rdata[CSR_OVR_MSK]  = msk_q.ovr;
    csr_rdata[CSR_AFUL_MSK] = msk_q.aful;
    csr_rdata[CSR_LOCK_MSK] = msk_q.lock;
    csr_rdata[CSR_OVR_FLG]  = flg_q.ovr;
    csr_rdata[CSR_AFUL_FLG] = flg_q.aful;
    csr_rdata[CSR_LOCK_FLG] = flg_q.lock;
    csr_rdata[CSR_THR_W-1:0] = thr_q;
  end

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && csr_we && csr_wdata[CSR_ACK] && csr_wdata[CSR_RUN]
     && !ev_pkt && !ev_ovr && !lock_evt) |=> (flg_q == '0 && !irq));
  p_ovr_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ev_ovr) |=> flg_q.ovr);
  p_quiet_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !irq);
  p_done_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ev_pkt && new_cnt == pkt_cnt_t'(thr_q)) |=> flg_q.done);
endmodule

// File: rtl/pkt_capture.sv
module pkt_capture
  import pkt_capture_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PKT_WORDS = 47,
  parameter int BUF_PKTS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              lock_evt,
  input  logic              csr_we,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              irq
);
  pkt_cnt_t cnt, new_cnt;
  logic     run, ev_pkt, ev_ovr;

  cap_wrgen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PKT_WORDS(PKT_WORDS), .BUF_PKTS(BUF_PKTS)
  ) u_wrgen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .base_we(base_we), .base_wdata(base_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data),
    .cnt(cnt), .ev_pkt(ev_pkt), .new_cnt(new_cnt), .ev_ovr(ev_ovr)
  );

  cap_csr #(.BUF_PKTS(BUF_PKTS)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cnt(cnt), .ev_pkt(ev_pkt), .new_cnt(new_cnt), .ev_ovr(ev_ovr),
    .lock_evt(lock_evt), .run(run), .irq(irq)
  );
endmodule

// File: tb/pkt_capture_bench.sv
`timescale 1ns/1ps
module pkt_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PKT_WORDS  = 47;
  localparam int BUF_PKTS   = 8;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        lock_evt = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        mem_wr;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 0;

  logic [63:0] exp_q[$];
  int          m_cnt;
  logic [31:0] m_base;
  int          m_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_capture u_pkt_capture (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lock_evt(lock_evt), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .base_we(base_we),
    .base_wdata(base_wdata), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor (R2)
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2/R5/R8 unexpected write actual=%h:%h expected=none", mem_addr, mem_data);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R2 write", {mem_addr}, e[63:32]);
        chk("R2 data", mem_data, e[31:0]);
      end
    end
  end

  always @(posedge clk) begin
    static int cyc = 0;
    cyc++;
    if (cyc > WATCHDOG && !done_run) begin
      done_run = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic csr_wr(input logic [31:0] v);
    @(negedge clk); csr_we = 1'b1; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic base_wr(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
    m_base = v; m_off = 0; m_cnt = 0;
  endtask

  // Driver: one packet, with idle gaps (R11)
  task automatic send_pkt(input logic [7:0] tag, input int gap);
    bit drop;
    drop = (m_cnt == BUF_PKTS);
    for (int w = 0; w < PKT_WORDS; w++) begin
      if (gap != 0 && (w % gap) == 1) begin
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {tag, 8'h5a, 16'(w)};
      @(posedge clk);
      if (in_ready && !drop) begin
        exp_q.push_back({m_base + 32'(m_off), tag, 8'h5a, 16'(w)});
        m_off += 4;
      end
    end
    @(negedge clk); in_valid = 1'b0;
    if (!drop) m_cnt++;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    chk("R2 queue empty", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    m_cnt = 0; m_base = 0; m_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 csr", csr_rdata, 32'h0002_7004);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 ready", {31'd0, in_ready}, 32'd0);

    base_wr(32'h1000_0000);
    csr_wr(32'h0000_B004); // run, done/ovr unmasked, aful/lock masked, thr 4
    chk("R11 ready when running", {31'd0, in_ready}, 32'd1);

    for (int p = 0; p < 3; p++) send_pkt(8'(p), 3 + p);
    drain();
    chk("R3 count 3", {24'd0, csr_rdata[31:24]}, 32'd3);
    chk("R4 done not yet", {31'd0, csr_rdata[16]}, 32'd0);
    chk("R6 irq low", {31'd0, irq}, 32'd0);

    send_pkt(8'h03, 0);
    drain();
    chk("R3 count 4", {24'd0, csr_rdata[31:24]}, 32'd4);
    chk("R4 done at threshold", {31'd0, csr_rdata[16]}, 32'd1);
    chk("R6 irq from done", {31'd0, irq}, 32'd1);

    csr_wr(32'h0000_B104);
    chk("R7 ack clears flags", {20'd0, csr_rdata[11:9], 8'd0, csr_rdata[16]}, 32'd0);
    chk("R7 ack drops irq", {31'd0, irq}, 32'd0);

    for (int p = 4; p < 7; p++) send_pkt(8'(p), 4);
    drain();
    chk("R10 almost-full at 7", {31'd0, csr_rdata[10]}, 32'd1);
    chk("R4 done not re-set past threshold", {31'd0, csr_rdata[16]}, 32'd0);
    chk("R6 masked aful no irq", {31'd0, irq}, 32'd0);

    send_pkt(8'h07, 2);
    send_pkt(8'h08, 0); // dropped
    drain();
    chk("R5 count stays 8", {24'd0, csr_rdata[31:24]}, 32'd8);
    chk("R5 overflow flag", {31'd0, csr_rdata[11]}, 32'd1);
    chk("R6 irq from overflow", {31'd0, irq}, 32'd1);

    @(negedge clk); lock_evt = 1'b1;
    @(negedge clk); lock_evt = 1'b0;
    chk("R10 lock flag", {31'd0, csr_rdata[9]}, 32'd1);

    csr_wr(32'h0000_F004); // ack bit clear, also mask overflow
    chk("R7 no ack keeps ovr", {31'd0, csr_rdata[11]}, 32'd1);
    chk("R6 all masked irq low", {31'd0, irq}, 32'd0);
    csr_wr(32'h0000_B004);
    chk("R6 unmask raises irq", {31'd0, irq}, 32'd1);

    base_wr(32'h2000_0000);
    chk("R9 rearm count 0", {24'd0, csr_rdata[31:24]}, 32'd0);
    send_pkt(8'h20, 5);
    drain();
    chk("R9 stored after rearm", {24'd0, csr_rdata[31:24]}, 32'd1);

    csr_wr(32'h0000_3004); // soft reset
    @(negedge clk);
    chk("R8 ready low", {31'd0, in_ready}, 32'd0);
    chk("R8 count zero", {24'd0, csr_rdata[31:24]}, 32'd0);
    chk("R8 flags zero", {20'd0, csr_rdata[11:9], 8'd0, csr_rdata[16]}, 32'd0);
    in_valid = 1'b1; in_data = 32'hdead_beef;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    csr_wr(32'h0000_B004);
    m_off = 0; m_cnt = 0;
    send_pkt(8'h30, 0);
    drain();
    chk("R8 restart count", {24'd0, csr_rdata[31:24]}, 32'd1);

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule